// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers a set of level-sensitive peripheral interrupt lines and a smaller set of software-settable interrupt flags, and forwards one of them at a time to the processor core as a request with a 9-bit vector number. Each source carries a 4-bit priority taken from a static configuration input. The block keeps a current priority: only a pending source whose priority is strictly above it can raise a request. When several sources qualify, the highest priority wins, and among equals the lowest vector number wins.

The core acknowledges a request with a one-cycle strobe. The controller then saves the old current priority on an internal last-in-first-out stack and adopts the priority of the serviced source, so that only more urgent sources can preempt the handler. A one-cycle end-of-interrupt strobe restores the saved priority. Software may also write the current priority directly. Raising it to the highest priority of the tasks that share a resource (a priority ceiling) masks every source at or below that level until the old value is written back.

The controller runs as a two-state machine. `ST_IDLE` arbitrates every cycle. The transition *grant* moves to `ST_REQ` when a qualifying winner exists and latches its vector and priority. `ST_REQ` drives the request to the core. It leaves by the transition *taken* on an acknowledge, or by the transition *withdraw* when the current priority has risen to or above the latched priority. Both transitions return to `ST_IDLE`.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the request output is low, the current priority is 0 and the priority stack is empty.
- R2: A request is raised only if the winning pending source has a priority strictly greater than the current priority. A source configured with priority 0 never raises a request.
- R3: Among pending qualifying sources, the one with the highest priority is presented.
- R4: Peripheral line i has vector i and software flag j has vector N_HW+j, which is 32+j by default. Among pending sources of equal priority, the lowest vector wins.
- R5: The vector output is registered. It stays unchanged from the cycle the request rises until the request is acknowledged or withdrawn, even if a more urgent source becomes pending meanwhile.
- R6: An acknowledge while the request is high does three things: it pushes the current priority onto the stack, it sets the current priority to the serviced source's priority, and it drops the request in the next cycle.
- R7: An end-of-interrupt pops the stack into the current priority. A pop from an empty stack yields 0.
- R8: A priority write sets the current priority directly, with no stack action. It masks all sources at or below the written level. It withdraws an outstanding request whose latched priority is no longer above the new level, and lowering the level again lets the request return.
- R9: Peripheral lines are level-sensitive. A line is pending only while it is asserted.
- R10: A software flag becomes pending on a set strobe and stays pending, across acknowledge and end-of-interrupt, until a clear strobe. A set and a clear in the same cycle leave it set.
- R11: When acknowledge, end-of-interrupt and a priority write coincide, the acknowledge takes effect first, then the end-of-interrupt, and the priority write takes effect only when neither of the other two occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_irq_i | input | N_HW | Peripheral interrupt lines, level-sensitive |
| sw_set_i | input | N_SW | Software flag set strobes |
| sw_clr_i | input | N_SW | Software flag clear strobes |
| prio_cfg_i | input | (N_HW+N_SW)*4 | Priority of source i in bits [4i+3:4i] |
| elev_we_i | input | 1 | Current-priority write strobe |
| elev_prio_i | input | 4 | Value for the current-priority write |
| ack_i | input | 1 | Acknowledge strobe from the core |
| eoi_i | input | 1 | End-of-interrupt strobe from the core |
| irq_req_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 9 | Vector number of the requested source |
| cur_prio_o | output | 4 | Current priority |

## Verification
The arbiter is tried with a lone source, with two sources at the same level, with two sources at different levels whose vector order opposes their priority order, and with a source at level 0. These cases separate a tie-break error from a priority comparison error and from a wrong threshold. Nesting is tried with a second, more urgent source arriving while a handler runs. Two consecutive ends-of-interrupt must then restore each saved level in turn, which tells a stack from a single save register. The priority write is tried below, at and above a pending source's level, and again while a request is outstanding, so that a non-strict comparison or a missed withdrawal shows. Software flags are checked to come back after an end-of-interrupt, which separates sticky flags from self-clearing ones.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int PRIO_W = 4;
    localparam int VEC_W  = 9;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } vic_state_e;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
    parameter int N_HW = 32,
    parameter int N_SW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_HW-1:0]      hw_irq_i,
    input  logic [N_SW-1:0]      sw_set_i,
    input  logic [N_SW-1:0]      sw_clr_i,
    output logic [N_HW+N_SW-1:0] pend_o
);
    logic [N_SW-1:0] sw_q;

    for (genvar j = 0; j < N_SW; j++) begin : g_sw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           sw_q[j] <= 1'b0;
            else if (sw_set_i[j]) sw_q[j] <= 1'b1;
            else if (sw_clr_i[j]) sw_q[j] <= 1'b0;
        end
    end

    assign pend_o = {sw_q, hw_irq_i};
endmodule

// File: rtl/vic_arb.sv
module vic_arb
    import vic_pkg::*;
#(
    parameter int N_SRC = 40
) (
    input  logic [N_SRC-1:0]        pend_i,
    input  logic [N_SRC*PRIO_W-1:0] prio_cfg_i,
    output logic [PRIO_W-1:0]       win_prio_o,
    output logic [VEC_W-1:0]        win_vec_o
);
    always_comb begin
        win_prio_o = '0;
        win_vec_o  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend_i[i] && (prio_cfg_i[i*PRIO_W +: PRIO_W] > win_prio_o)) begin
                win_prio_o = prio_cfg_i[i*PRIO_W +: PRIO_W];
                win_vec_o  = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic_stack.sv
module vic_stack
    import vic_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [PRIO_W-1:0] din_i,
    output logic [PRIO_W-1:0] top_o
);
    localparam int SP_W = $clog2(DEPTH + 1);
    localparam int A_W  = $clog2(DEPTH);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp;
    logic              full;
    logic              empty;

    assign full  = (sp == SP_W'(DEPTH));
    assign empty = (sp == '0);

    always_ff @(posedge clk) begin
        if (push_i && !full) mem[sp[A_W-1:0]] <= din_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sp <= '0;
        else if (push_i && !full)   sp <= sp + 1'b1;
        else if (pop_i && !empty)   sp <= sp - 1'b1;
    end

    assign top_o = empty ? '0 : mem[A_W'(sp - 1'b1)];
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import vic_pkg::*;
#(
    parameter int N_HW  = 32,
    parameter int N_SW  = 8,
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_HW-1:0]             hw_irq_i,
    input  logic [N_SW-1:0]             sw_set_i,
    input  logic [N_SW-1:0]             sw_clr_i,
    input  logic [(N_HW+N_SW)*4-1:0]    prio_cfg_i,
    input  logic                        elev_we_i,
    input  logic [3:0]                  elev_prio_i,
    input  logic                        ack_i,
    input  logic                        eoi_i,
    output logic                        irq_req_o,
    output logic [8:0]                  irq_vec_o,
    output logic [3:0]                  cur_prio_o
);
    localparam int N_SRC = N_HW + N_SW;

    vic_state_e        state_q, state_d;
    logic [N_SRC-1:0]  pend;
    logic [PRIO_W-1:0] win_prio, prio_q, cur_q, stk_top;
    logic [VEC_W-1:0]  win_vec, vec_q;
    logic              ack_take, pop;

    vic_pend #(.N_HW(N_HW), .N_SW(N_SW)) u_pend (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq_i),
        .sw_set_i(sw_set_i), .sw_clr_i(sw_clr_i), .pend_o(pend)
    );

    vic_arb #(.N_SRC(N_SRC)) u_arb (
        .pend_i(pend), .prio_cfg_i(prio_cfg_i),
        .win_prio_o(win_prio), .win_vec_o(win_vec)
    );

    vic_stack #(.DEPTH(DEPTH)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(ack_take), .pop_i(pop),
        .din_i(cur_q), .top_o(stk_top)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (win_prio > cur_q)  state_d = ST_REQ;   // grant
            ST_REQ: begin
                if (ack_take)               state_d = ST_IDLE;  // taken
                else if (prio_q <= cur_q)   state_d = ST_IDLE;  // withdraw
            end
            default:                        state_d = ST_IDLE;
        endcase
    end

    // State register and latched winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            prio_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_REQ) begin
                vec_q  <= win_vec;
                prio_q <= win_prio;
            end
        end
    end

    // Current priority: acknowledge, then end-of-interrupt, then write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cur_q <= '0;
        else if (ack_take)  cur_q <= prio_q;
        else if (eoi_i)     cur_q <= stk_top;
        else if (elev_we_i) cur_q <= elev_prio_i;
    end

    // Outputs
    always_comb begin
        irq_req_o  = (state_q == ST_REQ) && (prio_q > cur_q);
        irq_vec_o  = vec_q;
        cur_prio_o = cur_q;
    end

    assign ack_take = ack_i && irq_req_o;
    assign pop      = eoi_i && !ack_take;
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
    parameter int N_SRC = 40
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_SRC*4-1:0]   prio_cfg_i,
    input logic                 ack_i,
    input logic                 irq_req_o,
    input logic [8:0]           irq_vec_o,
    input logic [3:0]           cur_prio_o
);
    logic [3:0] vec_prio;
    assign vec_prio = prio_cfg_i[int'(irq_vec_o)*4 +: 4];

    a_r2_above_current: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (vec_prio > cur_prio_o));

    a_r5_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !ack_i) |=> (!irq_req_o || $stable(irq_vec_o)));

    a_r6_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && ack_i) |=> (cur_prio_o == $past(vec_prio)));

    a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && ack_i) |=> !irq_req_o);
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(.N_SRC(N_HW + N_SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prio_cfg_i(prio_cfg_i), .ack_i(ack_i),
    .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o), .cur_prio_o(cur_prio_o)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_HW = 32;
    localparam int N_SW = 8;
    localparam int N_SRC = N_HW + N_SW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_HW-1:0]   hw_irq = '0;
    logic [N_SW-1:0]   sw_set = '0;
    logic [N_SW-1:0]   sw_clr = '0;
    logic [N_SRC*4-1:0] prio_cfg = '0;
    logic              elev_we = 1'b0;
    logic [3:0]        elev_prio = '0;
    logic              ack = 1'b0;
    logic              eoi = 1'b0;
    logic              irq_req;
    logic [8:0]        irq_vec;
    logic [3:0]        cur_prio;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq), .sw_set_i(sw_set),
        .sw_clr_i(sw_clr), .prio_cfg_i(prio_cfg), .elev_we_i(elev_we),
        .elev_prio_i(elev_prio), .ack_i(ack), .eoi_i(eoi),
        .irq_req_o(irq_req), .irq_vec_o(irq_vec), .cur_prio_o(cur_prio)
    );

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    task automatic do_elev(int p);
        elev_we = 1'b1; elev_prio = 4'(p); tick(); elev_we = 1'b0;
    endtask

    task automatic set_prio(int src, int p);
        prio_cfg[src*4 +: 4] = 4'(p);
    endtask

    task automatic t_reset();
        check("R1 req", int'(irq_req), 0);
        check("R1 cur", int'(cur_prio), 0);
        do_eoi();
        check("R1 empty pop", int'(cur_prio), 0);
    endtask

    task automatic t_single();
        hw_irq[5] = 1'b1; tick(2);
        check("R2 req single", int'(irq_req), 1);
        check("R2 vec single", int'(irq_vec), 5);
        do_ack();
        check("R6 cur after ack", int'(cur_prio), 3);
        check("R6 req dropped", int'(irq_req), 0);
        hw_irq[5] = 1'b0;
        do_eoi(); tick(2);
        check("R7 cur after eoi", int'(cur_prio), 0);
        check("R9 line released", int'(irq_req), 0);
    endtask

    task automatic t_tie();
        hw_irq[9] = 1'b1; hw_irq[4] = 1'b1; tick(2);
        check("R4 tie req", int'(irq_req), 1);
        check("R4 tie vec", int'(irq_vec), 4);
        do_ack(); hw_irq[9] = 1'b0; hw_irq[4] = 1'b0;
        do_eoi(); tick(2);
        check("R4 tie clean", int'(irq_req), 0);
    endtask

    task automatic t_higher();
        hw_irq[2] = 1'b1; hw_irq[20] = 1'b1; tick(2);
        check("R3 higher vec", int'(irq_vec), 20);
        do_ack(); hw_irq[2] = 1'b0; hw_irq[20] = 1'b0;
        do_eoi(); tick(2);
        check("R3 clean", int'(irq_req), 0);
    endtask

    task automatic t_prio0();
        hw_irq[3] = 1'b1; tick(4);
        check("R2 prio0 silent", int'(irq_req), 0);
        hw_irq[3] = 1'b0;
    endtask

    task automatic t_stable();
        hw_irq[2] = 1'b1; tick(2);
        check("R5 first vec", int'(irq_vec), 2);
        hw_irq[20] = 1'b1; tick(3);
        check("R5 held vec", int'(irq_vec), 2);
        check("R5 still req", int'(irq_req), 1);
        do_ack(); tick(2);
        check("R5 rearb vec", int'(irq_vec), 20);
        do_ack(); hw_irq[2] = 1'b0; hw_irq[20] = 1'b0;
        do_eoi();
        check("R7 pop level1", int'(cur_prio), 1);
        do_eoi();
        check("R7 pop level0", int'(cur_prio), 0);
    endtask

    task automatic t_nest();
        hw_irq[1] = 1'b1; tick(2);
        check("R6 nest outer vec", int'(irq_vec), 1);
        do_ack();
        check("R6 nest cur2", int'(cur_prio), 2);
        hw_irq[6] = 1'b1; tick(2);
        check("R6 nest inner vec", int'(irq_vec), 6);
        do_ack();
        check("R6 nest cur6", int'(cur_prio), 6);
        hw_irq[6] = 1'b0; hw_irq[1] = 1'b0;
        do_eoi();
        check("R7 nest back2", int'(cur_prio), 2);
        do_eoi();
        check("R7 nest back0", int'(cur_prio), 0);
    endtask

    task automatic t_sw();
        sw_set[2] = 1'b1; tick(); sw_set[2] = 1'b0; tick();
        check("R10 sw req", int'(irq_req), 1);
        check("R4 sw vec", int'(irq_vec), 34);
        do_ack(); do_eoi(); tick();
        check("R10 sw sticky", int'(irq_req), 1);
        do_ack();
        sw_clr[2] = 1'b1; tick(); sw_clr[2] = 1'b0;
        do_eoi(); tick(3);
        check("R10 sw cleared", int'(irq_req), 0);
        sw_set[5] = 1'b1; sw_clr[5] = 1'b1; tick();
        sw_set[5] = 1'b0; sw_clr[5] = 1'b0; tick();
        check("R10 set wins", int'(irq_req), 1);
        check("R10 set wins vec", int'(irq_vec), 37);
        do_ack();
        sw_clr[5] = 1'b1; tick(); sw_clr[5] = 1'b0;
        do_eoi(); tick(2);
        check("R10 clean", int'(irq_req), 0);
    endtask

    task automatic t_elev();
        do_elev(4);
        check("R8 cur written", int'(cur_prio), 4);
        hw_irq[7] = 1'b1; tick(4);
        check("R8 masked at level", int'(irq_req), 0);
        do_elev(3); tick();
        check("R8 unmasked", int'(irq_req), 1);
        check("R8 vec", int'(irq_vec), 7);
        do_elev(4);
        check("R8 withdraw", int'(irq_req), 0);
        tick(2);
        check("R8 stays withdrawn", int'(irq_req), 0);
        do_elev(0); tick();
        check("R8 returns", int'(irq_req), 1);
        do_ack(); hw_irq[7] = 1'b0;
        do_eoi();
        check("R8 no stack use", int'(cur_prio), 0);
    endtask

    task automatic t_order();
        hw_irq[12] = 1'b1; tick(2);
        check("R11 req", int'(irq_req), 1);
        ack = 1'b1; elev_we = 1'b1; elev_prio = 4'd1; tick();
        ack = 1'b0; elev_we = 1'b0;
        check("R11 ack over write", int'(cur_prio), 5);
        hw_irq[12] = 1'b0;
        eoi = 1'b1; elev_we = 1'b1; elev_prio = 4'd9; tick();
        eoi = 1'b0; elev_we = 1'b0;
        check("R11 eoi over write", int'(cur_prio), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        set_prio(1, 2);  set_prio(2, 1);  set_prio(3, 0);
        set_prio(4, 2);  set_prio(5, 3);  set_prio(6, 6);
        set_prio(7, 4);  set_prio(9, 2);  set_prio(12, 5);
        set_prio(20, 7); set_prio(34, 5); set_prio(37, 6);
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_single();
        t_tie();
        t_higher();
        t_prio0();
        t_stable();
        t_nest();
        t_sw();
        t_elev();
        t_order();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule